// File: doc/BRIEF.md
# Compact Per-Warp Dependency Scoreboard

This block tracks in-flight register writes for a multithreaded core that runs many warps. Each warp has a small table of pending destination registers (six by default, out of 128 architectural registers), rather than one bit for every register. When an instruction is decoded into one of its warp's buffer entries, its source and destination register numbers are compared with that warp's table. The block stores a dependency vector with the entry, one bit for each table slot that the instruction waits on. An entry is offered to the scheduler as ready only when its vector is all zeros.

When a ready entry issues and it writes a register, the block gives it the lowest free slot of its warp and returns that slot number. The slot number must come back with the writeback. A writeback frees the slot and clears that slot's bit in every buffered entry of the same warp. Writebacks can therefore arrive in any order. A writeback that names a slot that is not in use raises a sticky error flag.

Top module: `wsb_scoreboard`

## Requirements
- R1: After reset, no entry is ready, no warp reports full, and `rel_err` is 0.
- R2: A decoded instruction whose source register matches a pending slot of its warp is not ready. It becomes ready in the cycle after the writeback of that slot.
- R3: A decoded instruction whose destination register matches a pending slot of its warp is not ready until that slot is written back.
- R4: A decoded instruction with no match is ready in the cycle after decode. An entry stops being ready in the cycle after it issues.
- R5: An issue returns on `iss_slot`, in the same cycle, the lowest-numbered free slot of the issuing warp. Slot numbers run from 0 to 5.
- R6: A writeback clears the slot's bit only in entries of the written-back warp. The entries of other warps keep their dependencies.
- R7: `warp_full[w]` is 1 while all six slots of warp w are in use. During that time an entry of that warp that writes a register is not ready, and an entry without a destination can still be ready.
- R8: A writeback and a decode in the same cycle, for the same warp and register, leave the decoded instruction with no dependency on that slot.
- R9: An issue and a decode in the same cycle, for the same warp, make the decoded instruction depend on the slot just given when its register matches.
- R10: A writeback naming a slot that is not in use (including slot numbers 6 and 7) sets `rel_err`. It stays set until reset.
- R11: An entry with several dependencies becomes ready only after all of them are written back, whatever order the writebacks arrive in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid | input | 1 | Decode writes an instruction into a buffer entry |
| dec_warp | input | 5 | Warp of the decoded instruction |
| dec_entry | input | 1 | Buffer entry within the warp |
| dec_src0_v | input | 1 | First source is used |
| dec_src0 | input | 7 | First source register |
| dec_src1_v | input | 1 | Second source is used |
| dec_src1 | input | 7 | Second source register |
| dec_dst_v | input | 1 | Instruction writes a register |
| dec_dst | input | 7 | Destination register |
| iss_valid | input | 1 | A ready entry issues |
| iss_warp | input | 5 | Warp of the issuing entry |
| iss_entry | input | 1 | Entry that issues |
| iss_slot | output | 3 | Slot given to the destination of the issuing entry |
| wb_valid | input | 1 | A result is written back |
| wb_warp | input | 5 | Warp of the writeback |
| wb_slot | input | 3 | Slot returned with the writeback |
| ready | output | 64 | Ready flag per entry, bit warp*2+entry |
| warp_full | output | 32 | All slots of the warp in use |
| rel_err | output | 1 | Sticky flag for a writeback to a free slot |

## Verification
Decode lookup can share a cycle with either of the two table updates. These are the writeback that frees a slot and the issue that takes one. The bench drives each pair in one clock: a decode that reads a register while its slot is written back, and a decode that reads the register an issuing instruction of the same warp is about to claim. Each case is judged by the entry's ready flag in the following cycle, and then by the flag after a later writeback.

// File: rtl/wsb_pkg.sv
package wsb_pkg;
  // Index of the lowest clear bit among the first n bits; n when none is clear.
  function automatic int unsigned lowest_zero(input logic [31:0] bits, input int unsigned n);
    lowest_zero = n;
    for (int i = 31; i >= 0; i--) begin
      if (i < int'(n) && !bits[i]) lowest_zero = i;
    end
  endfunction

  // Width of an index able to address n items, never below one bit.
  function automatic int unsigned idx_width(input int unsigned n);
    idx_width = (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/wsb_slot_table.sv
module wsb_slot_table
  import wsb_pkg::*;
#(
  parameter int NW = 32,
  parameter int NS = 6,
  parameter int RW = 7,
  localparam int WW = idx_width(NW),
  localparam int SW = idx_width(NS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_en,
  input  logic [WW-1:0] alloc_warp,
  input  logic [RW-1:0] alloc_reg,
  output logic [SW-1:0] alloc_slot,
  input  logic          rel_en,
  input  logic [WW-1:0] rel_warp,
  input  logic [SW-1:0] rel_slot,
  output logic          rel_ok,
  output logic          rel_bad,
  input  logic [WW-1:0] lk_warp,
  input  logic          lk_s0_v,
  input  logic [RW-1:0] lk_s0,
  input  logic          lk_s1_v,
  input  logic [RW-1:0] lk_s1,
  input  logic          lk_d_v,
  input  logic [RW-1:0] lk_d,
  output logic [NS-1:0] lk_vec,
  output logic [NW-1:0] full
);
  localparam int PADW = 2 ** SW;

  logic [NS-1:0] vld [NW];
  logic [RW-1:0] tag [NW][NS];
  logic [PADW-1:0] rel_row;

  assign alloc_slot = SW'(lowest_zero(32'(vld[alloc_warp]), NS));
  assign rel_row    = PADW'(vld[rel_warp]);
  assign rel_ok     = rel_en && rel_row[rel_slot];
  assign rel_bad    = rel_en && !rel_row[rel_slot];

  always_comb begin
    for (int s = 0; s < NS; s++) begin
      logic pend, fwd, h0, h1, hd;
      pend = vld[lk_warp][s] && !(rel_ok && rel_warp == lk_warp && rel_slot == SW'(s));
      fwd  = alloc_en && alloc_warp == lk_warp && alloc_slot == SW'(s);
      h0 = (pend && tag[lk_warp][s] == lk_s0) || (fwd && alloc_reg == lk_s0);
      h1 = (pend && tag[lk_warp][s] == lk_s1) || (fwd && alloc_reg == lk_s1);
      hd = (pend && tag[lk_warp][s] == lk_d)  || (fwd && alloc_reg == lk_d);
      lk_vec[s] = (lk_s0_v && h0) || (lk_s1_v && h1) || (lk_d_v && hd);
    end
  end

  for (genvar w = 0; w < NW; w++) begin : g_full
    assign full[w] = &vld[w];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int w = 0; w < NW; w++) vld[w] <= '0;
    end else begin
      if (rel_ok) vld[rel_warp][rel_slot] <= 1'b0;
      if (alloc_en) begin
        vld[alloc_warp][alloc_slot] <= 1'b1;
        tag[alloc_warp][alloc_slot] <= alloc_reg;
      end
    end
  end

  // R7
  alloc_has_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |-> !full[alloc_warp]);
  // R5
  alloc_marks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |=> vld[$past(alloc_warp)][$past(alloc_slot)]);
endmodule

// File: rtl/wsb_dep_buffer.sv
module wsb_dep_buffer
  import wsb_pkg::*;
#(
  parameter int NW = 32,
  parameter int NE = 2,
  parameter int NS = 6,
  parameter int RW = 7,
  localparam int WW = idx_width(NW),
  localparam int EW = idx_width(NE),
  localparam int SW = idx_width(NS),
  localparam int NT = NW * NE
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [WW-1:0] wr_warp,
  input  logic [EW-1:0] wr_entry,
  input  logic [NS-1:0] wr_vec,
  input  logic          wr_dst_v,
  input  logic [RW-1:0] wr_dst,
  input  logic          iss_en,
  input  logic [WW-1:0] iss_warp,
  input  logic [EW-1:0] iss_entry,
  output logic          iss_dst_v,
  output logic [RW-1:0] iss_dst,
  input  logic          clr_en,
  input  logic [WW-1:0] clr_warp,
  input  logic [SW-1:0] clr_slot,
  input  logic [NW-1:0] full,
  output logic [NT-1:0] ready
);
  function automatic int unsigned ent(input logic [WW-1:0] w, input logic [EW-1:0] e);
    ent = int'(w) * NE + int'(e);
  endfunction

  logic          occ [NT];
  logic [NS-1:0] vec [NT];
  logic          dv  [NT];
  logic [RW-1:0] dst [NT];

  assign iss_dst_v = dv[ent(iss_warp, iss_entry)];
  assign iss_dst   = dst[ent(iss_warp, iss_entry)];

  for (genvar i = 0; i < NT; i++) begin : g_rdy
    assign ready[i] = occ[i] && (vec[i] == '0) && !(dv[i] && full[i / NE]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NT; i++) begin
        occ[i] <= 1'b0;
        vec[i] <= '0;
        dv[i]  <= 1'b0;
      end
    end else begin
      if (clr_en) begin
        for (int e = 0; e < NE; e++) vec[int'(clr_warp) * NE + e][clr_slot] <= 1'b0;
      end
      if (iss_en) occ[ent(iss_warp, iss_entry)] <= 1'b0;
      if (wr_en) begin
        occ[ent(wr_warp, wr_entry)] <= 1'b1;
        vec[ent(wr_warp, wr_entry)] <= wr_vec;
        dv[ent(wr_warp, wr_entry)]  <= wr_dst_v;
        dst[ent(wr_warp, wr_entry)] <= wr_dst;
      end
    end
  end

  // R4
  issue_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iss_en |-> ready[ent(iss_warp, iss_entry)]);
endmodule

// File: rtl/wsb_scoreboard.sv
module wsb_scoreboard
  import wsb_pkg::*;
#(
  parameter int NW = 32,
  parameter int NE = 2,
  parameter int NS = 6,
  parameter int NR = 128,
  localparam int RW = idx_width(NR),
  localparam int WW = idx_width(NW),
  localparam int EW = idx_width(NE),
  localparam int SW = idx_width(NS),
  localparam int NT = NW * NE
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dec_valid,
  input  logic [WW-1:0] dec_warp,
  input  logic [EW-1:0] dec_entry,
  input  logic          dec_src0_v,
  input  logic [RW-1:0] dec_src0,
  input  logic          dec_src1_v,
  input  logic [RW-1:0] dec_src1,
  input  logic          dec_dst_v,
  input  logic [RW-1:0] dec_dst,
  input  logic          iss_valid,
  input  logic [WW-1:0] iss_warp,
  input  logic [EW-1:0] iss_entry,
  output logic [SW-1:0] iss_slot,
  input  logic          wb_valid,
  input  logic [WW-1:0] wb_warp,
  input  logic [SW-1:0] wb_slot,
  output logic [NT-1:0] ready,
  output logic [NW-1:0] warp_full,
  output logic          rel_err
);
  logic          iss_dst_v;
  logic [RW-1:0] iss_dst;
  logic          alloc_en;
  logic          rel_ok, rel_bad;
  logic [NS-1:0] dep_vec;
  logic [$clog2(NT)-1:0] dec_idx;

  assign alloc_en = iss_valid && iss_dst_v;
  assign dec_idx  = $clog2(NT)'(int'(dec_warp) * NE + int'(dec_entry));

  wsb_slot_table #(.NW(NW), .NS(NS), .RW(RW)) u_table (
    .clk(clk), .rst_n(rst_n),
    .alloc_en(alloc_en), .alloc_warp(iss_warp), .alloc_reg(iss_dst), .alloc_slot(iss_slot),
    .rel_en(wb_valid), .rel_warp(wb_warp), .rel_slot(wb_slot), .rel_ok(rel_ok), .rel_bad(rel_bad),
    .lk_warp(dec_warp), .lk_s0_v(dec_src0_v), .lk_s0(dec_src0), .lk_s1_v(dec_src1_v),
    .lk_s1(dec_src1), .lk_d_v(dec_dst_v), .lk_d(dec_dst), .lk_vec(dep_vec), .full(warp_full)
  );

  wsb_dep_buffer #(.NW(NW), .NE(NE), .NS(NS), .RW(RW)) u_buf (
    .clk(clk), .rst_n(rst_n),
    .wr_en(dec_valid), .wr_warp(dec_warp), .wr_entry(dec_entry), .wr_vec(dep_vec),
    .wr_dst_v(dec_dst_v), .wr_dst(dec_dst),
    .iss_en(iss_valid), .iss_warp(iss_warp), .iss_entry(iss_entry),
    .iss_dst_v(iss_dst_v), .iss_dst(iss_dst),
    .clr_en(rel_ok), .clr_warp(wb_warp), .clr_slot(wb_slot),
    .full(warp_full), .ready(ready)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) rel_err <= 1'b0;
    else if (rel_bad) rel_err <= 1'b1;
  end

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rel_err |=> rel_err);
  // R2
  dep_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dep_vec != '0) |=> !ready[$past(dec_idx)]);
endmodule

// File: tb/wsb_scoreboard_test.sv
`timescale 1ns/1ps
module wsb_scoreboard_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dec_valid = 0, dec_entry = 0, dec_src0_v = 0, dec_src1_v = 0, dec_dst_v = 0;
  logic [4:0] dec_warp = 0, iss_warp = 0, wb_warp = 0;
  logic [6:0] dec_src0 = 0, dec_src1 = 0, dec_dst = 0;
  logic iss_valid = 0, iss_entry = 0, wb_valid = 0;
  logic [2:0] wb_slot = 0, iss_slot;
  logic [63:0] ready;
  logic [31:0] warp_full;
  logic rel_err;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  wsb_scoreboard uut (.*);

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic rdy(int w, int e);
    return ready[w * 2 + e];
  endfunction

  task automatic tick(); @(negedge clk); endtask

  task automatic do_reset();
    rst_n = 0; dec_valid = 0; iss_valid = 0; wb_valid = 0;
    tick(); tick();
    rst_n = 1;
    tick();
  endtask

  task automatic set_dec(int w, int e, bit s0v, int s0, bit s1v, int s1, bit dv, int d);
    dec_valid = 1; dec_warp = 5'(w); dec_entry = 1'(e);
    dec_src0_v = s0v; dec_src0 = 7'(s0); dec_src1_v = s1v; dec_src1 = 7'(s1);
    dec_dst_v = dv; dec_dst = 7'(d);
  endtask

  task automatic decode(int w, int e, bit s0v, int s0, bit s1v, int s1, bit dv, int d);
    set_dec(w, e, s0v, s0, s1v, s1, dv, d);
    tick();
    dec_valid = 0;
  endtask

  task automatic issue(int w, int e, output int slot);
    iss_valid = 1; iss_warp = 5'(w); iss_entry = 1'(e);
    #1 slot = int'(iss_slot);
    tick();
    iss_valid = 0;
  endtask

  task automatic wb(int w, int s);
    wb_valid = 1; wb_warp = 5'(w); wb_slot = 3'(s);
    tick();
    wb_valid = 0;
  endtask

  task automatic push(int w, int d, output int slot);
    decode(w, 0, 0, 0, 0, 0, 1, d);
    issue(w, 0, slot);
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 ready", ready, 64'h0);
    check("R1 full", 64'(warp_full), 64'h0);
    check("R1 err", 64'(rel_err), 64'h0);
  endtask

  task automatic t_raw();
    int s;
    do_reset();
    decode(0, 0, 0, 0, 0, 0, 1, 7);
    check("R4 ready after decode", 64'(rdy(0, 0)), 64'h1);
    issue(0, 0, s);
    check("R5 first slot", 64'(s), 64'h0);
    check("R4 not ready after issue", 64'(rdy(0, 0)), 64'h0);
    decode(0, 0, 1, 7, 0, 0, 1, 8);
    check("R2 raw blocks", 64'(rdy(0, 0)), 64'h0);
    decode(0, 1, 0, 0, 1, 7, 0, 0);
    check("R2 raw on second source", 64'(rdy(0, 1)), 64'h0);
    decode(3, 0, 1, 7, 0, 0, 0, 0);
    check("R6 other warp free", 64'(rdy(3, 0)), 64'h1);
    wb(0, 0);
    check("R2 ready after writeback", 64'(rdy(0, 0)), 64'h1);
    check("R2 second entry ready", 64'(rdy(0, 1)), 64'h1);
    check("R10 no error", 64'(rel_err), 64'h0);
  endtask

  task automatic t_waw();
    int s;
    do_reset();
    push(2, 5, s);
    decode(2, 1, 0, 0, 0, 0, 1, 5);
    check("R3 waw blocks", 64'(rdy(2, 1)), 64'h0);
    decode(2, 0, 1, 1, 0, 0, 1, 9);
    check("R4 unrelated ready", 64'(rdy(2, 0)), 64'h1);
    wb(2, s);
    check("R3 ready after writeback", 64'(rdy(2, 1)), 64'h1);
  endtask

  task automatic t_order();
    int s0, s1, s2, s3;
    do_reset();
    push(1, 10, s0); push(1, 11, s1); push(1, 12, s2);
    check("R5 slots in order", 64'({s0[7:0], s1[7:0], s2[7:0]}), 64'h000102);
    push(2, 10, s3);
    decode(2, 0, 1, 10, 0, 0, 0, 0);
    decode(1, 0, 1, 10, 1, 12, 0, 0);
    decode(1, 1, 1, 11, 0, 0, 1, 12);
    check("R11 both blocked", 64'({rdy(1, 0), rdy(1, 1)}), 64'h0);
    wb(1, 2);
    check("R11 still blocked", 64'({rdy(1, 0), rdy(1, 1)}), 64'h0);
    wb(1, 0);
    check("R11 first ready", 64'({rdy(1, 0), rdy(1, 1)}), 64'h2);
    check("R6 other warp kept", 64'(rdy(2, 0)), 64'h0);
    wb(1, 1);
    check("R11 both ready", 64'({rdy(1, 0), rdy(1, 1)}), 64'h3);
    issue(1, 1, s0);
    check("R5 reuse lowest", 64'(s0), 64'h0);
  endtask

  task automatic t_full();
    int s;
    do_reset();
    for (int r = 0; r < 6; r++) begin
      push(4, r, s);
      check("R5 fill slot", 64'(s), 64'(r));
    end
    check("R7 full set", 64'(warp_full), 64'h10);
    decode(4, 0, 0, 0, 0, 0, 1, 20);
    check("R7 dst blocked while full", 64'(rdy(4, 0)), 64'h0);
    decode(4, 1, 1, 30, 0, 0, 0, 0);
    check("R7 no-dst ready while full", 64'(rdy(4, 1)), 64'h1);
    wb(4, 3);
    check("R7 full cleared", 64'(warp_full), 64'h0);
    check("R7 dst ready", 64'(rdy(4, 0)), 64'h1);
    issue(4, 0, s);
    check("R5 freed hole", 64'(s), 64'h3);
    check("R7 full again", 64'(warp_full), 64'h10);
  endtask

  task automatic t_same_wb();
    int s;
    do_reset();
    push(5, 7, s);
    set_dec(5, 0, 1, 7, 0, 0, 0, 0);
    wb_valid = 1; wb_warp = 5; wb_slot = 3'(s);
    tick();
    dec_valid = 0; wb_valid = 0;
    check("R8 decode with writeback", 64'(rdy(5, 0)), 64'h1);
  endtask

  task automatic t_fwd();
    int s;
    do_reset();
    decode(6, 0, 0, 0, 0, 0, 1, 9);
    set_dec(6, 1, 0, 0, 1, 9, 0, 0);
    iss_valid = 1; iss_warp = 6; iss_entry = 0;
    #1 s = int'(iss_slot);
    tick();
    dec_valid = 0; iss_valid = 0;
    check("R9 slot", 64'(s), 64'h0);
    check("R9 decode during issue blocked", 64'(rdy(6, 1)), 64'h0);
    wb(6, 0);
    check("R9 ready after writeback", 64'(rdy(6, 1)), 64'h1);
  endtask

  task automatic t_err();
    do_reset();
    wb(7, 2);
    check("R10 err set", 64'(rel_err), 64'h1);
    tick(); tick();
    check("R10 err held", 64'(rel_err), 64'h1);
    check("R10 no slot touched", 64'(warp_full), 64'h0);
    do_reset();
    check("R1 err cleared", 64'(rel_err), 64'h0);
    wb(0, 6);
    check("R10 out of range slot", 64'(rel_err), 64'h1);
  endtask

  initial begin
    tick();
    t_reset();
    t_raw();
    t_waw();
    t_order();
    t_full();
    t_same_wb();
    t_fwd();
    t_err();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule